// File: doc/BRIEF.md
# Reset Cause and Soft Reset Trigger Register

This block keeps a small record of why the chip was last reset, and lets software start a reset. It sits on a simple register port and decodes one aligned 8-byte pair at a base address (byte offset 0xF020 by default). Only the upper 32-bit word of the pair, the one with byte-address bit 2 set, does anything. In that word only the top five bits are used. The other bits read as zero and writes to them are dropped.

Writes to the upper word do two things. Writing a one to a cause bit clears it. Writing a one to one of the two soft-trigger bits sets that bit and sends a one-cycle pulse on the reset-request output to the chip's reset logic. The block also holds a flag that says whether the next system reset counts as a power-on reset. Power-up sets the flag, and so does a soft power-on trigger. When `sys_rst_i` arrives with the flag set, the register is loaded with only the power-on bit set, and the flag is cleared. When `sys_rst_i` arrives with the flag clear, the register keeps its value.

Top module: `rst_cause_reg`

## Requirements
- R1: After the asynchronous power-up reset `rst_n`, reads of the upper word return 0x00000000 and `reset_req_o` is 0.
- R2: The first `sys_rst_i` pulse after power-up loads the register with 0x80000000: bit 31 set, every other bit clear.
- R3: A `sys_rst_i` pulse while no power-on is pending leaves the register unchanged.
- R4: In a write to the upper word, a one in bit 31, bit 28 or bit 27 clears that register bit, and a zero leaves it as it was.
- R5: In a write to the upper word, a one in bit 30 (soft power-on) or bit 29 (soft external) sets that register bit, and a zero leaves it as it was.
- R6: Bits 26 to 0 of write data are ignored, and those bits always read as 0.
- R7: A write to the upper word with bit 30 set gives a `reset_req_o` pulse exactly one cycle long, in the cycle after the write. It also makes the next `sys_rst_i` load 0x80000000.
- R8: A write to the upper word with bit 29 set and bit 30 clear gives the same one-cycle pulse. It does not make a power-on pending.
- R9: The lower word (byte-address bit 2 clear) and every address outside the decoded pair read as 0, and writes to them change nothing and raise no request.
- R10: A write that arrives in the same cycle as `sys_rst_i` is dropped. It changes no register bit, raises no request and makes no power-on pending.
- R11: A write to the upper word with bits 30 and 29 both clear raises no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sys_rst_i | input | 1 | Synchronous system reset event, one cycle per reset |
| sel_i | input | 1 | Register port select |
| wr_i | input | 1 | Write strobe (read when low) |
| waddr_i | input | ADDR_W-2 (14) | Word address, byte-address bits ADDR_W-1 to 2 |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, combinational from the address |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach is the pending power-on flag, because no port shows it. Its value only appears as the contents of the register after the next `sys_rst_i`. The bench therefore ends every sweep step with a system reset. It predicts whether that reset reloads 0x80000000, depending on whether the setup write or the test write carried bit 30. A write that collides with `sys_rst_i` is then checked the same way: the register is first cleared to zero, so that a wrongly armed flag would show up as bit 31 after the following reset.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  // Number of functional bits, kept at the top of the word
  localparam int unsigned NUM_CAUSE = 5;

  // Index of each functional bit within the 5-bit field (word bit = LSB + index)
  localparam int unsigned IDX_BTN_EXT  = 0;
  localparam int unsigned IDX_BTN_POR  = 1;
  localparam int unsigned IDX_SOFT_EXT = 2;
  localparam int unsigned IDX_SOFT_POR = 3;
  localparam int unsigned IDX_POWER_ON = 4;

  typedef logic [NUM_CAUSE-1:0] cause_t;

  // Write-one-to-clear bits: power-on, button power-on, button external
  localparam cause_t W1C_MASK = cause_t'(5'b10011);
  // Write-one-to-set bits: the two soft triggers
  localparam cause_t W1S_MASK = cause_t'(5'b01100);
  // Value loaded on a power-on class reset
  localparam cause_t POR_LOAD = cause_t'(5'b10000);

  typedef enum logic [1:0] {
    BIT_KEEP  = 2'd0,
    BIT_CLEAR = 2'd1,
    BIT_SET   = 2'd2
  } bit_kind_e;

  function automatic bit_kind_e kind_of(input int unsigned idx);
    if (W1C_MASK[idx])      return BIT_CLEAR;
    else if (W1S_MASK[idx]) return BIT_SET;
    else                    return BIT_KEEP;
  endfunction

endpackage

// File: rtl/rst_cause_decode.sv
module rst_cause_decode #(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 16'hF020
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-3:0] waddr_i,
  output logic              wr_hi_o,
  output logic              rd_hi_o
);

  localparam int unsigned TAG_W = ADDR_W - 3;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:3];

  logic pair_hit;
  logic hi_word;

  always_comb begin
    pair_hit = (waddr_i[ADDR_W-3:1] == BASE_TAG);
    hi_word  = waddr_i[0];
    wr_hi_o  = sel_i & wr_i & pair_hit & hi_word;
    rd_hi_o  = sel_i & ~wr_i & pair_hit & hi_word;
  end

endmodule

// File: rtl/rst_cause_field.sv
module rst_cause_field
  import rst_cause_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sys_rst_i,
  input  logic   por_pend_i,
  input  logic   wr_hi_i,
  input  cause_t wfield_i,
  output cause_t cause_q_o
);

  cause_t cause_q;
  cause_t cause_d;
  logic   cause_en;

  // Per-bit next state, variant chosen by the bit's kind
  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_bit
    localparam bit_kind_e KIND = kind_of(g);
    always_comb begin
      if (sys_rst_i) begin
        cause_d[g] = por_pend_i ? POR_LOAD[g] : cause_q[g];
      end else if (wr_hi_i) begin
        case (KIND)
          BIT_CLEAR: cause_d[g] = cause_q[g] & ~wfield_i[g];
          BIT_SET:   cause_d[g] = cause_q[g] | wfield_i[g];
          default:   cause_d[g] = cause_q[g];
        endcase
      end else begin
        cause_d[g] = cause_q[g];
      end
    end
  end

  assign cause_en = sys_rst_i | wr_hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  assign cause_q_o = cause_q;

endmodule

// File: rtl/rst_cause_trigger.sv
module rst_cause_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst_i,
  input  logic wr_hi_i,
  input  logic soft_por_i,
  input  logic soft_ext_i,
  output logic por_pend_o,
  output logic req_o
);

  logic pend_q, pend_d, pend_en;
  logic req_q, req_d;

  always_comb begin
    pend_en = sys_rst_i | (wr_hi_i & soft_por_i);
    pend_d  = ~sys_rst_i;
    req_d   = ~sys_rst_i & wr_hi_i & (soft_por_i | soft_ext_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign por_pend_o = pend_q;
  assign req_o      = req_q;

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int unsigned       DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-3:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reset_req_o
);

  localparam int unsigned FIELD_LSB = DATA_W - NUM_CAUSE;

  logic        wr_hi;
  logic        rd_hi;
  logic        por_pend;
  cause_t      wfield;
  cause_t      cause_q;
  logic [DATA_W-1:0] cause_word;

  assign wfield = wdata_i[DATA_W-1:FIELD_LSB];

  rst_cause_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .waddr_i (waddr_i),
    .wr_hi_o (wr_hi),
    .rd_hi_o (rd_hi)
  );

  rst_cause_trigger u_trigger (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_rst_i  (sys_rst_i),
    .wr_hi_i    (wr_hi),
    .soft_por_i (wfield[IDX_SOFT_POR]),
    .soft_ext_i (wfield[IDX_SOFT_EXT]),
    .por_pend_o (por_pend),
    .req_o      (reset_req_o)
  );

  rst_cause_field u_field (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_rst_i  (sys_rst_i),
    .por_pend_i (por_pend),
    .wr_hi_i    (wr_hi),
    .wfield_i   (wfield),
    .cause_q_o  (cause_q)
  );

  assign cause_word = {cause_q, {FIELD_LSB{1'b0}}};
  assign rdata_o    = rd_hi ? cause_word : '0;

endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int unsigned       DATA_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_rst_i,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-3:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              reset_req_o,
  input logic [DATA_W-1:0] cause_word
);

  localparam logic [DATA_W-1:0] POR_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  logic hi_sel;
  logic wr_top;
  logic pend_m;

  assign hi_sel = sel_i && (waddr_i == BASE_ADDR[ADDR_W-1:2] + 1'b1);
  assign wr_top = hi_sel && wr_i && !sys_rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pend_m <= 1'b1;
    else if (sys_rst_i)                  pend_m <= 1'b0;
    else if (wr_top && wdata_i[DATA_W-2]) pend_m <= 1'b1;
  end

  // R2
  por_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i && pend_m |=> cause_word == POR_WORD);

  // R3
  warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i && !pend_m |=> $stable(cause_word));

  // R4
  w1c_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_top && wdata_i[DATA_W-1] |=> !cause_word[DATA_W-1]);

  // R5
  w1s_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_top && wdata_i[DATA_W-2] |=> cause_word[DATA_W-2]);

  // R7
  req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> $past(wr_top && (wdata_i[DATA_W-2] || wdata_i[DATA_W-3])));

  // R9
  other_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i && wr_i && !hi_sel && !sys_rst_i |=> $stable(cause_word));

  // R9
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_sel && !wr_i) |-> rdata_o == '0);

  // R10
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i && sel_i && wr_i && !pend_m |=> $stable(cause_word) && !reset_req_o);

endmodule

bind rst_cause_reg rst_cause_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .DATA_W    (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sys_rst_i   (sys_rst_i),
  .sel_i       (sel_i),
  .wr_i        (wr_i),
  .waddr_i     (waddr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .reset_req_o (reset_req_o),
  .cause_word  (cause_word)
);

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;

  localparam logic [13:0] A_HI  = 14'h3C09;
  localparam logic [13:0] A_LO  = 14'h3C08;
  localparam logic [13:0] A_OUT = 14'h3C0B;

  logic        clk;
  logic        rst_n;
  logic        sys_rst;
  logic        sel;
  logic        wr;
  logic [13:0] waddr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        req;

  int n_chk = 0;
  int n_err = 0;

  rst_cause_reg u_rst_cause_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst_i   (sys_rst),
    .sel_i       (sel),
    .wr_i        (wr),
    .waddr_i     (waddr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .reset_req_o (req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic power_up();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic do_read(input logic [13:0] a, output logic [31:0] v);
    sel = 1'b1; wr = 1'b0; waddr = a;
    #1 v = rdata;
    sel = 1'b0;
  endtask

  task automatic sys_pulse();
    @(negedge clk);
    sys_rst = 1'b1;
    @(negedge clk);
    sys_rst = 1'b0;
  endtask

  function automatic logic [4:0] apply_wr(input logic [4:0] m, input logic [4:0] w);
    return (m & ~(w & 5'b10011)) | (w & 5'b01100);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b1; sys_rst = 1'b0; sel = 1'b0; wr = 1'b0; waddr = '0; wdata = '0;

    // R1 reset state
    power_up();
    @(negedge clk);
    do_read(A_HI, v);
    check("R1 reset read", v, 32'h0);
    check("R1 reset req", {31'b0, req}, 32'h0);

    // Sweep: 8 start states x 32 write patterns
    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 32; w++) begin
        logic [4:0] m;
        logic [4:0] wf;
        logic       pend;
        logic [31:0] wv;
        power_up();
        sys_pulse();
        do_read(A_HI, v);
        check("R2 first reset load", v, 32'h8000_0000);
        m = 5'b10000;
        pend = 1'b0;
        if (s[2] == 1'b0) begin
          do_write(A_HI, 32'h8000_0000);
          m = 5'b00000;
        end
        if (s[1:0] != 2'b00) begin
          do_write(A_HI, {1'b0, s[1], s[0], 29'h0});
          m = m | {1'b0, s[1], s[0], 2'b00};
          pend = s[1];
        end
        do_read(A_HI, v);
        check("R5 setup state", v, {m, 27'h0});
        wf = w[4:0];
        wv = {wf, 27'h5A5_A5A5 ^ 27'(w)};
        do_write(A_HI, wv);
        // R7 R8 R11 pulse in the cycle after the write
        check("R7 R8 R11 req", {31'b0, req}, {31'b0, wf[3] | wf[2]});
        m = apply_wr(m, wf);
        pend = pend | wf[3];
        do_read(A_HI, v);
        // R4 R5 R6
        check("R4 R5 R6 after write", v, {m, 27'h0});
        @(negedge clk);
        check("R7 one cycle", {31'b0, req}, 32'h0);
        sys_pulse();
        do_read(A_HI, v);
        if (pend) check("R7 pending power-on", v, 32'h8000_0000);
        else      check("R3 R8 warm reset hold", v, {m, 27'h0});
      end
    end

    // R9 lower word and outside address
    power_up();
    sys_pulse();
    do_read(A_LO, v);
    check("R9 lower read zero", v, 32'h0);
    do_write(A_LO, 32'hFFFF_FFFF);
    check("R9 lower no req", {31'b0, req}, 32'h0);
    do_read(A_HI, v);
    check("R9 lower write ignored", v, 32'h8000_0000);
    do_write(A_OUT, 32'hF800_0000);
    check("R9 outside no req", {31'b0, req}, 32'h0);
    do_read(A_HI, v);
    check("R9 outside write ignored", v, 32'h8000_0000);
    do_read(A_OUT, v);
    check("R9 outside read zero", v, 32'h0);

    // R10 write colliding with system reset
    do_write(A_HI, 32'h8000_0000);
    @(negedge clk);
    sys_rst = 1'b1; sel = 1'b1; wr = 1'b1; waddr = A_HI; wdata = 32'h6000_0000;
    @(negedge clk);
    sys_rst = 1'b0; sel = 1'b0; wr = 1'b0;
    check("R10 collide no req", {31'b0, req}, 32'h0);
    do_read(A_HI, v);
    check("R10 collide dropped", v, 32'h0);
    sys_pulse();
    do_read(A_HI, v);
    check("R10 no pending armed", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule